// File: doc/BRIEF.md
# Atomic Operation Placement Predictor

This block decides, per atomic memory operation, whether the operation should run locally in the requesting core's L1 cache or be sent outward to a shared cache level or to memory. The idea is that a cache block that one CPU keeps touching on its own is best kept near that CPU. A block that several CPUs use in turn is better handled at a shared level, so the line does not keep moving between cores.

A small direct-mapped table is indexed by cache-block address. Each entry stores an address tag, the ID of the CPU that used the block most recently, and a saturating run counter. The counter holds how many consecutive accesses that CPU has made. Each request presents a block address and a CPU ID. The one-bit verdict appears combinationally in the same cycle, and the entry is updated on the next rising clock edge. Executing the atomic operation and keeping caches coherent are the job of other blocks.

Top module: `amo_place_predictor`

## Requirements
- R1: The entry for a request is selected by the low `IDX_W` bits of `reqBlockAddr`. The remaining upper bits form the tag. A request hits only when the selected entry is valid and its tag matches.
- R2: On a miss, `predLocal` is 0. On the next rising edge the entry is filled with the request's tag and CPU ID, and its run count is set to 1.
- R3: On a hit by the recorded CPU, the run count rises by one on the next edge. It saturates at 2^`CNT_W`-1 and never wraps to a smaller value.
- R4: On a hit by a CPU other than the recorded one, `predLocal` is 0. On the next edge the new CPU ID is recorded and the run count restarts at 1.
- R5: `predLocal` is 1 only for a hit by the recorded CPU whose stored run count is at least `LIMIT`. That is, the access must follow more than `LIMIT`-1 earlier consecutive accesses by the same CPU. With the defaults (`LIMIT`=3), the fourth consecutive access by one CPU is the first local one.
- R6: The decision depends only on the current inputs and the table contents, within the same cycle. A request's update is visible to a request in the following cycle.
- R7: While `reqValid` is 0, `predLocal` is 0 and no entry changes, whatever the values on `reqBlockAddr` and `reqCpuId`.
- R8: While `rst` is 1, `predLocal` is 0, and a rising edge with `rst` at 1 invalidates every entry. After this, every first access misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; invalidates the table |
| reqValid | input | 1 | An atomic request is presented this cycle |
| reqBlockAddr | input | ADDR_W | Cache-block address of the request |
| reqCpuId | input | CPU_W | ID of the requesting CPU |
| predLocal | output | 1 | 1: run in local L1; 0: send to the outer level |

## Verification
The bench follows a single CPU's run through the limit and keeps going well past counter saturation. A counter that wrapped would suddenly predict remote in the middle of a long private run, and an off-by-one limit compare would turn local one access early or one access late. It also interleaves a second CPU and a conflicting tag on the same index. A design that failed to restart the count or to replace the owner would keep predicting local for a block that has changed hands. Idle cycles carrying foreign addresses and IDs are inserted between accesses, and a reset is applied in the middle of a run. Both would expose updates that leak through `reqValid` or entries that survive reset.

// File: rtl/amo_place_pkg.sv
package amo_place_pkg;

  // strobes from the control path to the table datapath
  typedef struct packed {
    logic wrEn;     // commit an update to the selected entry
    logic restart;  // new owner or new block: run count back to 1
    logic bump;     // same owner continues: saturating increment
  } amo_strobe_t;

endpackage

// File: rtl/amo_place_dpath.sv
module amo_place_dpath
  import amo_place_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CPU_W  = 3,
  parameter int CNT_W  = 3,
  parameter int IDX_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       reqBlockAddr,
  input  logic [CPU_W-1:0]        reqCpuId,
  input  amo_strobe_t             strobe,
  output logic                    rdValid,
  output logic [ADDR_W-IDX_W-1:0] rdTag,
  output logic [CPU_W-1:0]        rdCpu,
  output logic [CNT_W-1:0]        rdCount,
  output logic [ADDR_W-IDX_W-1:0] reqTag
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [DEPTH-1:0]            entryValid;
  logic [DEPTH-1:0][TAG_W-1:0] entryTag;
  logic [DEPTH-1:0][CPU_W-1:0] entryCpu;
  logic [DEPTH-1:0][CNT_W-1:0] entryCnt;

  logic [IDX_W-1:0] reqIdx;
  logic [CNT_W-1:0] nextCount;

  assign reqIdx = reqBlockAddr[IDX_W-1:0];
  assign reqTag = reqBlockAddr[ADDR_W-1:IDX_W];

  assign rdValid = entryValid[reqIdx];
  assign rdTag   = entryTag[reqIdx];
  assign rdCpu   = entryCpu[reqIdx];
  assign rdCount = entryCnt[reqIdx];

  always_comb begin
    if (strobe.restart)
      nextCount = CNT_ONE;
    else if (rdCount == CNT_MAX)
      nextCount = CNT_MAX;
    else
      nextCount = rdCount + CNT_ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      entryValid <= '0;
      entryTag   <= '0;
      entryCpu   <= '0;
      entryCnt   <= '0;
    end else if (strobe.wrEn) begin
      entryValid[reqIdx] <= 1'b1;
      entryTag[reqIdx]   <= reqTag;
      entryCpu[reqIdx]   <= reqCpuId;
      entryCnt[reqIdx]   <= nextCount;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> entryValid == '0); // R8

  AST_OWNER_RECORDED: assert property (@(posedge clk) disable iff (rst)
    strobe.wrEn |=> entryValid[$past(reqIdx)] &&
                    entryCpu[$past(reqIdx)] == $past(reqCpuId) &&
                    entryTag[$past(reqIdx)] == $past(reqTag)); // R4

  AST_RUN_RESTART: assert property (@(posedge clk) disable iff (rst)
    strobe.wrEn && strobe.restart |=> entryCnt[$past(reqIdx)] == CNT_ONE); // R2

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    strobe.wrEn && strobe.bump && rdCount == CNT_MAX
      |=> entryCnt[$past(reqIdx)] == CNT_MAX); // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !strobe.wrEn |=> $stable(entryCnt) && $stable(entryCpu) && $stable(entryValid)); // R7

endmodule

// File: rtl/amo_place_ctrl.sv
module amo_place_ctrl
  import amo_place_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CPU_W  = 3,
  parameter int CNT_W  = 3,
  parameter int IDX_W  = 3,
  parameter int LIMIT  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reqValid,
  input  logic [CPU_W-1:0]        reqCpuId,
  input  logic [ADDR_W-IDX_W-1:0] reqTag,
  input  logic                    rdValid,
  input  logic [ADDR_W-IDX_W-1:0] rdTag,
  input  logic [CPU_W-1:0]        rdCpu,
  input  logic [CNT_W-1:0]        rdCount,
  output amo_strobe_t             strobe,
  output logic                    predLocal
);

  localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

  logic accept;
  logic tagHit;
  logic sameOwner;
  logic runLong;

  assign accept    = reqValid && !rst;
  assign tagHit    = rdValid && (rdTag == reqTag);
  assign sameOwner = tagHit && (rdCpu == reqCpuId);
  assign runLong   = rdCount >= LIMIT_C;

  always_comb begin
    strobe         = '0;
    strobe.wrEn    = accept;
    strobe.bump    = sameOwner;
    strobe.restart = !sameOwner;
  end

  assign predLocal = accept && sameOwner && runLong;

  AST_MISS_REMOTE: assert property (@(posedge clk) disable iff (rst)
    reqValid && !(rdValid && rdTag == reqTag) |-> !predLocal); // R2

  AST_FOREIGN_REMOTE: assert property (@(posedge clk) disable iff (rst)
    reqValid && rdCpu != reqCpuId |-> !predLocal); // R4

  AST_IDLE_REMOTE: assert property (@(posedge clk) disable iff (rst)
    !reqValid |-> !predLocal && !strobe.wrEn); // R7

  AST_LOCAL_HAS_RUN: assert property (@(posedge clk) disable iff (rst)
    predLocal |-> rdCount != '0); // R5

endmodule

// File: rtl/amo_place_predictor.sv
module amo_place_predictor
  import amo_place_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CPU_W  = 3,
  parameter int CNT_W  = 3,
  parameter int IDX_W  = 3,
  parameter int LIMIT  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqBlockAddr,
  input  logic [CPU_W-1:0]  reqCpuId,
  output logic              predLocal
);

  localparam int TAG_W = ADDR_W - IDX_W;

  amo_strobe_t      strobe;
  logic             rdValid;
  logic [TAG_W-1:0] rdTag;
  logic [CPU_W-1:0] rdCpu;
  logic [CNT_W-1:0] rdCount;
  logic [TAG_W-1:0] reqTag;

  amo_place_ctrl #(
    .ADDR_W(ADDR_W), .CPU_W(CPU_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .LIMIT(LIMIT)
  ) uCtrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqCpuId(reqCpuId),
    .reqTag(reqTag), .rdValid(rdValid), .rdTag(rdTag), .rdCpu(rdCpu),
    .rdCount(rdCount), .strobe(strobe), .predLocal(predLocal)
  );

  amo_place_dpath #(
    .ADDR_W(ADDR_W), .CPU_W(CPU_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) uDpath (
    .clk(clk), .rst(rst), .reqBlockAddr(reqBlockAddr), .reqCpuId(reqCpuId),
    .strobe(strobe), .rdValid(rdValid), .rdTag(rdTag), .rdCpu(rdCpu),
    .rdCount(rdCount), .reqTag(reqTag)
  );

  initial begin
    assert (LIMIT >= 1 && LIMIT < (1 << CNT_W) && IDX_W < ADDR_W); // R5
  end

endmodule

// File: tb/amo_place_predictor_test.sv
module amo_place_predictor_test;

  localparam int ADDR_W = 16;
  localparam int CPU_W  = 3;
  localparam int CNT_W  = 3;
  localparam int IDX_W  = 3;
  localparam int LIMIT  = 3;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqBlockAddr = '0;
  logic [CPU_W-1:0]  reqCpuId = '0;
  logic              predLocal;

  int nVec = 0;
  int nBad = 0;
  bit done = 0;

  // behavioural reference table
  int mValid[DEPTH];
  int mTag[DEPTH];
  int mCpu[DEPTH];
  int mCnt[DEPTH];

  always #4 clk = ~clk;

  amo_place_predictor #(
    .ADDR_W(ADDR_W), .CPU_W(CPU_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .LIMIT(LIMIT)
  ) uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqBlockAddr(reqBlockAddr),
    .reqCpuId(reqCpuId), .predLocal(predLocal)
  );

  task automatic modelClear();
    for (int i = 0; i < DEPTH; i++) begin
      mValid[i] = 0; mTag[i] = 0; mCpu[i] = 0; mCnt[i] = 0;
    end
  endtask

  task automatic compare(input bit exp, input string req);
    nVec++;
    if (predLocal !== exp) begin
      nBad++;
      $display("FAIL %s: addr=%h cpu=%0d valid=%0b predLocal=%b expected=%b",
               req, reqBlockAddr, reqCpuId, reqValid, predLocal, exp);
    end
  endtask

  // one request cycle: drive, check verdict, then advance model
  task automatic step(input bit v, input int addr, input int cpu, input string req);
    int idx, tag;
    bit hit, same, exp;
    @(negedge clk);
    reqValid = v;
    reqBlockAddr = ADDR_W'(addr);
    reqCpuId = CPU_W'(cpu);
    #1;
    idx  = addr % DEPTH;
    tag  = (addr & ((1 << ADDR_W) - 1)) >> IDX_W;
    hit  = (mValid[idx] != 0) && (mTag[idx] == tag);
    same = hit && (mCpu[idx] == cpu);
    exp  = v && same && (mCnt[idx] >= LIMIT);
    compare(exp, req);
    if (v) begin
      mValid[idx] = 1;
      mTag[idx] = tag;
      if (same) mCnt[idx] = (mCnt[idx] == CMAX) ? CMAX : mCnt[idx] + 1;
      else      mCnt[idx] = 1;
      mCpu[idx] = cpu;
    end
  endtask

  task automatic doReset(input int cycles);
    @(negedge clk);
    rst = 1'b1;
    reqValid = 1'b1;
    #1;
    compare(1'b0, "R8");
    repeat (cycles) @(posedge clk);
    modelClear();
    @(negedge clk);
    rst = 1'b0;
    reqValid = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    nBad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finishRun();
  end

  initial begin
    modelClear();
    doReset(3);

    // R1 R2 R8: every index misses after reset
    for (int i = 0; i < DEPTH; i++) step(1, 16'h0100 + i, 1, "R8");

    // R5 R6: single owner crosses the limit on the fourth access
    step(1, 16'h2345, 2, "R2");
    step(1, 16'h2345, 2, "R5");
    step(1, 16'h2345, 2, "R5");
    step(1, 16'h2345, 2, "R5");
    step(1, 16'h2345, 2, "R6");

    // R3: long run past saturation stays local
    for (int i = 0; i < 12; i++) step(1, 16'h2345, 2, "R3");

    // R7: idle cycles with foreign address and ID change nothing
    step(0, 16'h2345, 5, "R7");
    step(0, 16'h2A45, 7, "R7");
    step(0, 16'h0005, 2, "R7");
    step(1, 16'h2345, 2, "R7");

    // R4: another CPU takes over and must rebuild its run
    step(1, 16'h2345, 6, "R4");
    step(1, 16'h2345, 2, "R4");
    for (int i = 0; i < 5; i++) step(1, 16'h2345, 2, "R4");

    // R1: same index, different tag evicts
    step(1, 16'h7FF5, 2, "R1");
    step(1, 16'h2345, 2, "R1");
    step(1, 16'h2345, 2, "R1");
    step(1, 16'h2345, 2, "R1");
    step(1, 16'h2345, 2, "R1");
    step(1, 16'h2346, 2, "R1");

    // R8: reset in the middle of a run
    doReset(2);
    step(1, 16'h2345, 2, "R8");
    step(1, 16'h2345, 2, "R8");

    // R6: mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int a, c, v;
      a = 16'h1230 + $urandom_range(0, 11) + ($urandom_range(0, 1) << 12);
      c = $urandom_range(0, 3) == 0 ? $urandom_range(0, 7) : (a % 2);
      v = $urandom_range(0, 7) != 0;
      step(v[0], a, c, "R6");
    end

    step(0, 0, 0, "R7");
    finishRun();
  end

endmodule